// File: doc/BRIEF.md
# Half-Duplex MII Transmit Engine with Collision Retry

This block is the transmit side of a MAC that drives a media-independent interface toward a PHY. A frame of `tx_len` bytes sits in a buffer outside the block. The block fetches it one byte at a time through a read port (`rd_addr` out, `rd_data` back in the same cycle). It sends a seven-byte `0x55` preamble and a `0xD5` start delimiter, then the frame bytes, as 4-bit nibbles on `txd` with `tx_en` high. One nibble leaves per clock. Before every attempt it defers until the carrier-sense input has been quiet for an interframe gap.

In half-duplex mode, a collision during the preamble or the data cuts the frame short. A jam pattern goes out in place of the rest of the frame. The block then waits a pseudo-random number of slot times under truncated binary exponential backoff. After that it rewinds the buffer read port to byte 0 and sends the whole frame again. After the sixteenth collision the frame is dropped and an abort pulse is given. A clean transmission ends with a done pulse.

Both PHY status inputs may change at any time relative to the clock, so each passes through a two-flop synchronizer. In full-duplex mode both inputs are ignored and every frame goes out once.

Top module: `mii_hdx_tx`

## Requirements
- R1: While `rst_n` is low: `tx_en`=0, `txd`=0, `rd_addr`=0, `tx_done`=0 and `tx_abort`=0.
- R2: Each attempt is one unbroken burst with `tx_en` high. It carries fifteen nibbles of 0x5, then one nibble of 0xD, then every frame byte from address 0 upward with bits [3:0] before bits [7:4]. Whenever `tx_en` is low, `txd` is 0.
- R3: `rd_addr` is 0 in the first cycle of every attempt, so a retried frame starts again from its first byte.
- R4: The first preamble nibble appears only after the synchronized carrier-sense has been low for IFG_NIBBLES (24) consecutive cycles. If `crs_async` falls while a start is pending, `tx_en` rises on the 26th clock after the fall (2 synchronizer stages plus 24).
- R5: In half-duplex mode, suppose `col_async` is high in the cycle that shows nibble k of the preamble or data. Nibbles 0..k+2 go out normally. They are followed by exactly JAM_NIBBLES (8) nibbles of 0x5, and then `tx_en` falls.
- R6: After the n-th collision of a frame, the number of `tx_en`-low cycles before the next attempt is IFG_NIBBLES + r·SLOT_NIBBLES, with 0 ≤ r ≤ 2^min(n,10) − 1.
- R7: Every retry sends the same nibble sequence as the first attempt.
- R8: After MAX_ATTEMPTS (16) collided attempts, `tx_abort` is high for one cycle, in the first cycle after the last jam nibble. No further attempt follows, and `tx_done` is not given for that frame.
- R9: A frame sent without collision produces a one-cycle `tx_done` pulse in the first cycle after its last data nibble.
- R10: With `full_duplex`=1, `col_async` and `crs_async` have no effect, and the frame is sent once, complete, ending in `tx_done`.
- R11: `tx_start` is only accepted while the block is idle. A start pulse during an ongoing frame produces no extra burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit nibble clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| full_duplex | input | 1 | 1: ignore carrier and collision, send once |
| tx_start | input | 1 | One-cycle request to send the buffered frame |
| tx_len | input | ADDR_W | Frame length in bytes (at least 1), sampled with `tx_start` |
| rd_addr | output | ADDR_W | Byte address into the frame buffer |
| rd_data | input | 8 | Buffer byte at `rd_addr`, same cycle |
| crs_async | input | 1 | Carrier sense from the PHY, unsynchronized |
| col_async | input | 1 | Collision from the PHY, unsynchronized |
| txd | output | 4 | Transmit nibble |
| tx_en | output | 1 | Transmit enable |
| tx_done | output | 1 | One-cycle pulse: frame sent |
| tx_abort | output | 1 | One-cycle pulse: frame dropped after too many collisions |

## Verification
The hardest case to reach from the ports is the sixteenth consecutive collision. It needs sixteen separate bursts, and each must be hit while the preamble is still on the wire. The wait before each burst is random, and it grows with every collision. To get there, the bench follows each burst: it waits for `tx_en` to rise, counts nibbles to a chosen index, raises the collision input, and lowers it again inside the jam. It measures every gap and checks it against the backoff window for that collision count, then checks that the abort pulse appears and that nothing is transmitted afterwards. A short slot time in the bench keeps the widest backoff windows within the run length.

// File: rtl/mii_tx_pkg.sv
package mii_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEFER,
    ST_PRE,
    ST_DATA,
    ST_JAM,
    ST_BACKOFF
  } tx_state_e;

  localparam logic [3:0] PRE_NIB = 4'h5;
  localparam logic [3:0] SFD_NIB = 4'hD;
  localparam logic [3:0] JAM_NIB = 4'h5;

endpackage

// File: rtl/mii_tx_sync.sv
module mii_tx_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/mii_tx_lfsr.sv
module mii_tx_lfsr #(
  parameter int           W     = 16,
  parameter int           OUT_W = 10,
  parameter logic [W-1:0] TAPS  = 16'hB400,
  parameter logic [W-1:0] SEED  = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [OUT_W-1:0] q
);

  logic [W-1:0] st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (adv) st_d = {st_q[W-2:0], ^(st_q & TAPS)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEED;
    else        st_q <= st_d;
  end

  assign q = st_q[OUT_W-1:0];

endmodule

// File: rtl/mii_tx_nibsel.sv
module mii_tx_nibsel
  import mii_tx_pkg::*;
(
  input  tx_state_e   state,
  input  logic        sfd,
  input  logic        hi,
  input  logic [7:0]  byte_in,
  output logic [3:0]  nib
);

  always_comb begin
    case (state)
      ST_PRE:  nib = sfd ? SFD_NIB : PRE_NIB;
      ST_DATA: nib = hi ? byte_in[7:4] : byte_in[3:0];
      ST_JAM:  nib = JAM_NIB;
      default: nib = 4'h0;
    endcase
  end

endmodule

// File: rtl/mii_hdx_tx.sv
module mii_hdx_tx
  import mii_tx_pkg::*;
#(
  parameter int ADDR_W        = 11,
  parameter int SLOT_NIBBLES  = 128,
  parameter int MAX_ATTEMPTS  = 16,
  parameter int BACKOFF_LIMIT = 10,
  parameter int IFG_NIBBLES   = 24,
  parameter int JAM_NIBBLES   = 8,
  parameter int SYNC_STAGES   = 2,
  parameter int LFSR_W        = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              full_duplex,
  input  logic              tx_start,
  input  logic [ADDR_W-1:0] tx_len,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  input  logic              crs_async,
  input  logic              col_async,
  output logic [3:0]        txd,
  output logic              tx_en,
  output logic              tx_done,
  output logic              tx_abort
);

  localparam int PRE_NIBS = 16;
  localparam int PRE_W    = $clog2(PRE_NIBS);
  localparam int ATT_W    = $clog2(MAX_ATTEMPTS + 1);
  localparam int IFG_W    = $clog2(IFG_NIBBLES + 1);
  localparam int JAM_W    = $clog2(JAM_NIBBLES + 1);
  localparam int SLOT_W   = $clog2(SLOT_NIBBLES + 1);
  localparam int R_W      = BACKOFF_LIMIT;

  tx_state_e          state_q, state_d;
  logic [ADDR_W-1:0]  len_q, len_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic               hi_q, hi_d;
  logic [PRE_W-1:0]   pre_q, pre_d;
  logic [ATT_W-1:0]   att_q, att_d;
  logic [IFG_W-1:0]   ifg_q, ifg_d;
  logic [JAM_W-1:0]   jam_q, jam_d;
  logic [R_W-1:0]     slot_q, slot_d;
  logic [SLOT_W-1:0]  nib_q, nib_d;
  logic               done_q, done_d;
  logic               abort_q, abort_d;

  logic [1:0]         sync_q;
  logic               crs_s, col_s;
  logic               crs_busy, col_hit;
  logic [R_W-1:0]     rnd;
  logic [ATT_W-1:0]   bo_exp;
  logic [R_W:0]       bo_span;
  logic [R_W-1:0]     bo_r;

  // PHY status into the clock domain
  mii_tx_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({crs_async, col_async}),
    .q     (sync_q)
  );
  assign crs_s = sync_q[1];
  assign col_s = sync_q[0];

  mii_tx_lfsr #(.W(LFSR_W), .OUT_W(R_W)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (1'b1),
    .q     (rnd)
  );

  assign crs_busy = !full_duplex && crs_s;
  assign col_hit  = !full_duplex && col_s &&
                    ((state_q == ST_PRE) || (state_q == ST_DATA));

  // truncated exponent and masked random slot count
  always_comb begin
    bo_exp  = (att_q > ATT_W'(BACKOFF_LIMIT)) ? ATT_W'(BACKOFF_LIMIT) : att_q;
    bo_span = (R_W+1)'(1) << bo_exp;
    bo_r    = rnd & R_W'(bo_span - 1'b1);
  end

  always_comb begin
    state_d = state_q;
    len_d   = len_q;
    addr_d  = addr_q;
    hi_d    = hi_q;
    pre_d   = pre_q;
    att_d   = att_q;
    ifg_d   = ifg_q;
    jam_d   = jam_q;
    slot_d  = slot_q;
    nib_d   = nib_q;
    done_d  = 1'b0;
    abort_d = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (tx_start) begin
          len_d   = tx_len;
          att_d   = '0;
          ifg_d   = '0;
          state_d = ST_DEFER;
        end
      end
      ST_DEFER: begin
        if (crs_busy) begin
          ifg_d = '0;
        end else if (ifg_q == IFG_W'(IFG_NIBBLES - 1)) begin
          pre_d   = '0;
          addr_d  = '0;
          hi_d    = 1'b0;
          state_d = ST_PRE;
        end else begin
          ifg_d = ifg_q + 1'b1;
        end
      end
      ST_PRE: begin
        if (col_hit) begin
          jam_d   = '0;
          att_d   = att_q + 1'b1;
          state_d = ST_JAM;
        end else if (pre_q == PRE_W'(PRE_NIBS - 1)) begin
          state_d = ST_DATA;
        end else begin
          pre_d = pre_q + 1'b1;
        end
      end
      ST_DATA: begin
        if (col_hit) begin
          jam_d   = '0;
          att_d   = att_q + 1'b1;
          state_d = ST_JAM;
        end else begin
          hi_d = !hi_q;
          if (hi_q) begin
            if (addr_q == len_q - 1'b1) begin
              done_d  = 1'b1;
              state_d = ST_IDLE;
            end else begin
              addr_d = addr_q + 1'b1;
            end
          end
        end
      end
      ST_JAM: begin
        if (jam_q == JAM_W'(JAM_NIBBLES - 1)) begin
          ifg_d = '0;
          nib_d = '0;
          if (att_q == ATT_W'(MAX_ATTEMPTS)) begin
            abort_d = 1'b1;
            state_d = ST_IDLE;
          end else begin
            slot_d  = bo_r;
            state_d = (bo_r == '0) ? ST_DEFER : ST_BACKOFF;
          end
        end else begin
          jam_d = jam_q + 1'b1;
        end
      end
      ST_BACKOFF: begin
        if (nib_q == SLOT_W'(SLOT_NIBBLES - 1)) begin
          nib_d = '0;
          if (slot_q == R_W'(1)) state_d = ST_DEFER;
          else                   slot_d  = slot_q - 1'b1;
        end else begin
          nib_d = nib_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      len_q   <= '0;
      addr_q  <= '0;
      hi_q    <= 1'b0;
      pre_q   <= '0;
      att_q   <= '0;
      ifg_q   <= '0;
      jam_q   <= '0;
      slot_q  <= '0;
      nib_q   <= '0;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      len_q   <= len_d;
      addr_q  <= addr_d;
      hi_q    <= hi_d;
      pre_q   <= pre_d;
      att_q   <= att_d;
      ifg_q   <= ifg_d;
      jam_q   <= jam_d;
      slot_q  <= slot_d;
      nib_q   <= nib_d;
      done_q  <= done_d;
      abort_q <= abort_d;
    end
  end

  mii_tx_nibsel u_nibsel (
    .state   (state_q),
    .sfd     (pre_q == PRE_W'(PRE_NIBS - 1)),
    .hi      (hi_q),
    .byte_in (rd_data),
    .nib     (txd)
  );

  assign tx_en    = (state_q == ST_PRE) || (state_q == ST_DATA) || (state_q == ST_JAM);
  assign rd_addr  = addr_q;
  assign tx_done  = done_q;
  assign tx_abort = abort_q;

endmodule

// File: rtl/mii_hdx_tx_chk.sv
module mii_hdx_tx_chk #(
  parameter int ADDR_W      = 11,
  parameter int IFG_NIBBLES = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_en,
  input logic [3:0]        txd,
  input logic              tx_done,
  input logic              tx_abort,
  input logic [ADDR_W-1:0] rd_addr
);

  localparam int CW = $clog2(IFG_NIBBLES + 2);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          low_cnt <= '0;
    else if (tx_en)                      low_cnt <= '0;
    else if (low_cnt != CW'(IFG_NIBBLES)) low_cnt <= low_cnt + 1'b1;
  end

  AST_TXD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> (txd == 4'h0)); // R2

  AST_GAP_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> (low_cnt >= CW'(IFG_NIBBLES))); // R4

  AST_REWIND_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> (rd_addr == '0)); // R3

  AST_DONE_AFTER_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (!tx_en && $past(tx_en))); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done); // R9

  AST_ABORT_AFTER_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |-> (!tx_en && $past(tx_en))); // R8

  AST_ABORT_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_abort && tx_done)); // R8

endmodule

bind mii_hdx_tx mii_hdx_tx_chk #(.ADDR_W(ADDR_W), .IFG_NIBBLES(IFG_NIBBLES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_en    (tx_en),
  .txd      (txd),
  .tx_done  (tx_done),
  .tx_abort (tx_abort),
  .rd_addr  (rd_addr)
);

// File: tb/sim_mii_hdx_tx.sv
module sim_mii_hdx_tx;

  localparam int AW   = 11;
  localparam int SLOT = 4;
  localparam int IFG  = 24;
  localparam int JAM  = 8;
  localparam int MAXA = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          full_duplex, tx_start, crs_async, col_async;
  logic [AW-1:0] tx_len, rd_addr;
  logic [7:0]    rd_data;
  logic [3:0]    txd;
  logic          tx_en, tx_done, tx_abort;

  logic [7:0] mem [64];
  assign rd_data = mem[rd_addr[5:0]];

  always #4 clk = ~clk;

  mii_hdx_tx #(.ADDR_W(AW), .SLOT_NIBBLES(SLOT), .IFG_NIBBLES(IFG),
               .JAM_NIBBLES(JAM), .MAX_ATTEMPTS(MAXA)) u0 (
    .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex), .tx_start(tx_start),
    .tx_len(tx_len), .rd_addr(rd_addr), .rd_data(rd_data),
    .crs_async(crs_async), .col_async(col_async), .txd(txd), .tx_en(tx_en),
    .tx_done(tx_done), .tx_abort(tx_abort)
  );

  typedef struct {
    logic [3:0] nib;
    bit         last;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  // driver side of the scoreboard: expected nibbles of one burst
  task automatic push_frame(input int len, input int cut, input string tag);
    logic [3:0] nb[$];
    exp_t e;
    for (int k = 0; k < 16; k++) nb.push_back((k == 15) ? 4'hD : 4'h5);
    for (int b = 0; b < len; b++) begin
      nb.push_back(mem[b][3:0]);
      nb.push_back(mem[b][7:4]);
    end
    if (cut < 0) begin
      for (int k = 0; k < nb.size(); k++) begin
        e.nib = nb[k]; e.last = (k == nb.size() - 1); e.tag = tag;
        exp_q.push_back(e);
      end
    end else begin
      for (int k = 0; k < cut; k++) begin
        e.nib = nb[k]; e.last = 1'b0; e.tag = tag;
        exp_q.push_back(e);
      end
      for (int k = 0; k < JAM; k++) begin
        e.nib = 4'h5; e.last = (k == JAM - 1); e.tag = "R5 jam";
        exp_q.push_back(e);
      end
    end
  endtask

  // monitor side of the scoreboard
  bit   prev_en = 0;
  exp_t last_pop;
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_en) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R11 unexpected nibble", int'(txd), -1);
        end else begin
          last_pop = exp_q.pop_front();
          chk(txd == last_pop.nib, last_pop.tag, int'(txd), int'(last_pop.nib));
        end
      end else if (prev_en) begin
        chk(last_pop.last, "R2 burst end", 0, 1);
      end
    end
    prev_en = tx_en;
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse_start(input int len);
    tx_len   = AW'(len);
    tx_start = 1'b1;
    tick();
    tx_start = 1'b0;
  endtask

  task automatic wait_en();
    while (!tx_en) tick();
  endtask

  task automatic wait_done(input string req);
    bit pe;
    pe = tx_en;
    while (!tx_done && !tx_abort) begin
      pe = tx_en;
      tick();
    end
    chk(tx_done && pe && !tx_en, req, int'(tx_done), 1);
  endtask

  // one collided attempt: collision raised at nibble idx
  task automatic collide(input int idx, input int att);
    int g, lim, r;
    wait_en();
    repeat (idx) tick();
    col_async = 1'b1;
    repeat (4) tick();
    col_async = 1'b0;
    while (tx_en) tick();
    if (att < MAXA) begin
      g = 0;
      while (!tx_en) begin
        g++;
        tick();
      end
      lim = 1 << ((att < 10) ? att : 10);
      r   = (g - IFG) / SLOT;
      chk(g >= IFG && ((g - IFG) % SLOT) == 0 && r < lim,
          "R6 backoff gap", g, IFG + (lim - 1) * SLOT);
    end else begin
      chk(tx_abort == 1'b1, "R8 abort pulse", int'(tx_abort), 1);
    end
  endtask

  initial begin
    int cnt, k;
    rst_n = 1'b0; full_duplex = 1'b0; tx_start = 1'b0; tx_len = '0;
    crs_async = 1'b0; col_async = 1'b0;
    for (int i = 0; i < 64; i++) mem[i] = 8'((i * 37 + 11) ^ 8'hA6);
    repeat (3) tick();
    chk(!tx_en && txd == 4'h0 && rd_addr == '0 && !tx_done && !tx_abort,
        "R1 reset state", int'(tx_en), 0);
    rst_n = 1'b1;
    repeat (2) tick();

    // clean frame, plus a start pulse while busy
    push_frame(5, -1, "R2 stream");
    pulse_start(5);
    wait_en();
    repeat (10) tick();
    pulse_start(2);
    wait_done("R9 done pulse");
    cnt = 0;
    repeat (100) begin
      tick();
      if (tx_en || tx_done) cnt++;
    end
    chk(cnt == 0, "R11 start while busy", cnt, 0);

    // deferral on carrier
    crs_async = 1'b1;
    push_frame(3, -1, "R2 stream");
    pulse_start(3);
    cnt = 0;
    repeat (40) begin
      tick();
      if (tx_en) cnt++;
    end
    chk(cnt == 0, "R4 held off by carrier", cnt, 0);
    crs_async = 1'b0;
    k = 0;
    do begin
      tick();
      k++;
    end while (!tx_en && k < 100);
    chk(k == IFG + 2, "R4 gap after carrier", k, IFG + 2);
    wait_done("R9 done pulse");

    // one collision in the data, then a clean retry
    for (int i = 0; i < 6; i++) mem[i] = 8'(8'h1F + i * 8'h2B);
    push_frame(6, 23, "R5 cut point");
    push_frame(6, -1, "R7 retry content");
    pulse_start(6);
    collide(20, 1);
    chk(rd_addr == '0, "R3 rewind", int'(rd_addr), 0);
    wait_done("R9 done after retry");
    repeat (5) tick();

    // sixteen collisions in the preamble
    for (int a = 1; a <= MAXA; a++) push_frame(4, 5, "R7 retry preamble");
    pulse_start(4);
    for (int a = 1; a <= MAXA; a++) collide(2, a);
    cnt = 0;
    repeat (200) begin
      tick();
      if (tx_en || tx_done) cnt++;
    end
    chk(cnt == 0, "R8 no further attempt", cnt, 0);

    // full duplex ignores both PHY inputs
    full_duplex = 1'b1; crs_async = 1'b1; col_async = 1'b1;
    push_frame(4, -1, "R10 full duplex");
    pulse_start(4);
    wait_done("R10 sent once");
    full_duplex = 1'b0; crs_async = 1'b0; col_async = 1'b0;
    repeat (5) tick();

    chk(exp_q.size() == 0, "R2 all bursts seen", exp_q.size(), 0);
    report();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      report();
      $finish;
    end
  end

endmodule